// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Controller

This block is the central bookkeeping controller for a small out-of-order execution core. Several functional units share one register file. Each cycle the block is offered at most one decoded instruction, made up of an operation code, a destination register, two source registers and a target unit, through a valid/ready handshake. It accepts instructions strictly in program order. For every unit it keeps a status record: the unit state, the operation, the destination, the two sources, the producing unit of each source, and one ready flag per source. It also keeps one table entry per register that names the unit that will write that register next.

From these tables the controller makes three decisions.

- **Issue.** It accepts an instruction only if the target unit is free and no unit has that destination pending, so write-after-write hazards never enter the machine.
- **Operand read.** It grants a unit permission to read its operands from the register file once both sources are ready, which resolves read-after-write hazards. Units can therefore start executing out of order.
- **Writeback.** When a unit reports completion, it holds the writeback back while any other unit still has to read the old value of the destination, which resolves write-after-read hazards. It grants one register-file write per cycle by fixed priority.

No value is ever forwarded. Operands come only from the register file.

Top module: `sb_ctrl`

## Requirements
- R1: After synchronous reset every unit is idle and no register has a pending writer. `in_ready` is 1 for any offered instruction, and `rd_grant` and `wb_grant` are all zero.
- R2: An instruction whose target unit is busy is not accepted (`in_ready`=0). It must stay offered, and no later instruction is accepted before it. One cycle after acceptance, `unit_op` slice `in_fu` (bits `in_fu*4 +: 4`) shows the accepted operation code.
- R3: An instruction whose destination register has a pending writer (issued and not yet written back) is not accepted.
- R4: `rd_grant[u]` is 1 only while unit u is waiting for operands and both of its source flags are ready. A source is ready when no unit was pending on it at issue, or once its producer has written back. The grant lasts one cycle per issued instruction, and grants to different units may come out of program order.
- R5: A source whose pending producer is granted writeback in the same cycle the consumer issues counts as ready at once. It does not wait for another writeback.
- R6: A unit that has completed is not granted writeback while another unit is waiting for operands with a ready source flag on a source register equal to that destination.
- R7: `wb_grant` is one-hot or zero. Among eligible units the lowest index wins, and `wb_reg` gives the winner's destination register. On writeback the unit becomes free, the destination's pending mark clears, and every waiting source that named the unit becomes ready.
- R8: A unit granted writeback in a cycle still counts as busy for issue in that cycle. An instruction targeting it is first accepted in the next cycle.
- R9: `done[u]` has an effect only while unit u is executing, meaning after its read grant and before its completion. Pulses at any other time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 4 | Operation code |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_fu | input | 2 | Target functional unit |
| done | input | 4 | Per-unit execution-complete pulse |
| rd_grant | output | 4 | Per-unit permission to read operands this cycle |
| wb_grant | output | 4 | One-hot writeback permission this cycle |
| wb_reg | output | 4 | Destination register of the granted writeback |
| unit_op | output | 16 | Operation code held by each unit, 4 bits per unit |

## Verification
The bench drives a long instruction stream over a handful of registers, so that true, anti and output dependences pile up. It also issues into units in the very cycle they write back, and sprinkles completion pulses onto units that are not executing.

A design that forgot the same-cycle writeback would leave a consumer waiting forever on a producer that has already gone. A design that skipped the write-after-read check would let a result overwrite a register that a waiting unit has not yet read. A design that freed Busy early would accept a second instruction into a unit that is still writing back. A design that honoured stray completion pulses would write back before its operands were read.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_NUM_FU  = 4;
    localparam int SB_NUM_REG = 16;
    localparam int SB_OP_W    = 4;
    localparam int SB_FU_W    = $clog2(SB_NUM_FU);
    localparam int SB_REG_W   = $clog2(SB_NUM_REG);
    localparam int SB_TAG_W   = $clog2(SB_NUM_FU + 1);

    typedef logic [SB_TAG_W-1:0] tag_t;   // 0 = no producer, u+1 = unit u
    typedef logic [SB_REG_W-1:0] reg_t;
    typedef logic [SB_OP_W-1:0]  op_t;
    typedef logic [SB_FU_W-1:0]  fu_t;

    typedef enum logic [1:0] {
        U_IDLE = 2'd0,
        U_WAIT = 2'd1,
        U_EXEC = 2'd2,
        U_DONE = 2'd3
    } ustate_e;

    typedef struct packed {
        op_t  op;
        reg_t dst;
        reg_t src1;
        reg_t src2;
    } iss_t;

    typedef struct packed {
        ustate_e st;
        op_t     op;
        reg_t    fi;
        reg_t    fj;
        reg_t    fk;
        tag_t    qj;
        tag_t    qk;
        logic    rj;
        logic    rk;
    } ustat_t;

    function automatic tag_t fu_tag(input int idx);
        return tag_t'(idx + 1);
    endfunction
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  reg_t set_reg,
    input  tag_t set_tag,
    input  logic clr_en,
    input  reg_t clr_reg,
    input  reg_t rd_a,
    input  reg_t rd_b,
    input  reg_t rd_d,
    output tag_t tag_a,
    output tag_t tag_b,
    output tag_t tag_d
);
    tag_t tbl [SB_NUM_REG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < SB_NUM_REG; r++) tbl[r] <= '0;
        end else begin
            if (clr_en) tbl[clr_reg] <= '0;
            if (set_en) tbl[set_reg] <= set_tag;
        end
    end

    assign tag_a = tbl[rd_a];
    assign tag_b = tbl[rd_b];
    assign tag_d = tbl[rd_d];
endmodule

// File: rtl/sb_unit.sv
module sb_unit
    import sb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   iss_en,
    input  iss_t   iss,
    input  tag_t   src_tag_a,
    input  tag_t   src_tag_b,
    input  tag_t   wb_tag,
    input  logic   done_in,
    input  logic   wb_win,
    output ustat_t stat,
    output logic   rd_grant
);
    tag_t qa, qb;
    logic wb_any;

    assign wb_any = (wb_tag != '0);
    // a producer writing back in the issue cycle no longer blocks the source
    assign qa = (wb_any && src_tag_a == wb_tag) ? '0 : src_tag_a;
    assign qb = (wb_any && src_tag_b == wb_tag) ? '0 : src_tag_b;
    assign rd_grant = (stat.st == U_WAIT) && stat.rj && stat.rk;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.st <= U_IDLE;
            stat.op <= '0;
            stat.fi <= '0;
            stat.fj <= '0;
            stat.fk <= '0;
            stat.qj <= '0;
            stat.qk <= '0;
            stat.rj <= 1'b0;
            stat.rk <= 1'b0;
        end else if (iss_en) begin
            stat.st <= U_WAIT;
            stat.op <= iss.op;
            stat.fi <= iss.dst;
            stat.fj <= iss.src1;
            stat.fk <= iss.src2;
            stat.qj <= qa;
            stat.qk <= qb;
            stat.rj <= (qa == '0);
            stat.rk <= (qb == '0);
        end else begin
            unique case (stat.st)
                U_WAIT: begin
                    if (rd_grant) begin
                        stat.st <= U_EXEC;
                        stat.rj <= 1'b0;
                        stat.rk <= 1'b0;
                    end else begin
                        if (wb_any && stat.qj == wb_tag) begin
                            stat.qj <= '0;
                            stat.rj <= 1'b1;
                        end
                        if (wb_any && stat.qk == wb_tag) begin
                            stat.qk <= '0;
                            stat.rk <= 1'b1;
                        end
                    end
                end
                U_EXEC: if (done_in) stat.st <= U_DONE;
                U_DONE: if (wb_win) stat.st <= U_IDLE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic [SB_NUM_FU-1:0] fin_v,
    input  logic [SB_NUM_FU-1:0] wait_v,
    input  logic [SB_NUM_FU-1:0] rj_v,
    input  logic [SB_NUM_FU-1:0] rk_v,
    input  reg_t [SB_NUM_FU-1:0] fi_a,
    input  reg_t [SB_NUM_FU-1:0] fj_a,
    input  reg_t [SB_NUM_FU-1:0] fk_a,
    output logic [SB_NUM_FU-1:0] wb_grant,
    output reg_t                 wb_reg,
    output tag_t                 wb_tag
);
    logic [SB_NUM_FU-1:0] war_block;
    logic [SB_NUM_FU-1:0] elig;

    for (genvar u = 0; u < SB_NUM_FU; u++) begin : g_war
        always_comb begin
            war_block[u] = 1'b0;
            for (int f = 0; f < SB_NUM_FU; f++) begin
                if (f != u && wait_v[f] &&
                    ((fj_a[f] == fi_a[u] && rj_v[f]) ||
                     (fk_a[f] == fi_a[u] && rk_v[f])))
                    war_block[u] = 1'b1;
            end
        end
        assign elig[u] = fin_v[u] && !war_block[u];
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        wb_grant = '0;
        wb_reg   = '0;
        wb_tag   = '0;
        for (int u = 0; u < SB_NUM_FU; u++) begin
            if (elig[u] && !found) begin
                found       = 1'b1;
                wb_grant[u] = 1'b1;
                wb_reg      = fi_a[u];
                wb_tag      = fu_tag(u);
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [SB_OP_W-1:0]            in_op,
    input  logic [SB_REG_W-1:0]           in_dst,
    input  logic [SB_REG_W-1:0]           in_src1,
    input  logic [SB_REG_W-1:0]           in_src2,
    input  logic [SB_FU_W-1:0]            in_fu,
    input  logic [SB_NUM_FU-1:0]          done,
    output logic [SB_NUM_FU-1:0]          rd_grant,
    output logic [SB_NUM_FU-1:0]          wb_grant,
    output logic [SB_REG_W-1:0]           wb_reg,
    output logic [SB_NUM_FU*SB_OP_W-1:0]  unit_op
);
    ustat_t               stat [SB_NUM_FU];
    logic [SB_NUM_FU-1:0] busy_vec;
    logic [SB_NUM_FU-1:0] fin_v, wait_v, rj_v, rk_v;
    reg_t [SB_NUM_FU-1:0] fi_a, fj_a, fk_a;
    tag_t                 tag_a, tag_b, tag_d, wb_tag;
    logic                 issue;
    iss_t                 iss;

    assign iss      = '{op: in_op, dst: in_dst, src1: in_src1, src2: in_src2};
    assign in_ready = !busy_vec[in_fu] && (tag_d == '0);
    assign issue    = in_valid && in_ready;

    sb_regstat u_regstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue),
        .set_reg (in_dst),
        .set_tag (fu_tag(int'(in_fu))),
        .clr_en  (|wb_grant),
        .clr_reg (wb_reg),
        .rd_a    (in_src1),
        .rd_b    (in_src2),
        .rd_d    (in_dst),
        .tag_a   (tag_a),
        .tag_b   (tag_b),
        .tag_d   (tag_d)
    );

    for (genvar u = 0; u < SB_NUM_FU; u++) begin : g_unit
        sb_unit u_unit (
            .clk       (clk),
            .rst       (rst),
            .iss_en    (issue && (in_fu == fu_t'(u))),
            .iss       (iss),
            .src_tag_a (tag_a),
            .src_tag_b (tag_b),
            .wb_tag    (wb_tag),
            .done_in   (done[u]),
            .wb_win    (wb_grant[u]),
            .stat      (stat[u]),
            .rd_grant  (rd_grant[u])
        );
        assign busy_vec[u] = (stat[u].st != U_IDLE);
        assign fin_v[u]    = (stat[u].st == U_DONE);
        assign wait_v[u]   = (stat[u].st == U_WAIT);
        assign rj_v[u]     = stat[u].rj;
        assign rk_v[u]     = stat[u].rk;
        assign fi_a[u]     = stat[u].fi;
        assign fj_a[u]     = stat[u].fj;
        assign fk_a[u]     = stat[u].fk;
        assign unit_op[u*SB_OP_W +: SB_OP_W] = stat[u].op;
    end

    sb_wb_arb u_arb (
        .fin_v    (fin_v),
        .wait_v   (wait_v),
        .rj_v     (rj_v),
        .rk_v     (rk_v),
        .fi_a     (fi_a),
        .fj_a     (fj_a),
        .fk_a     (fk_a),
        .wb_grant (wb_grant),
        .wb_reg   (wb_reg),
        .wb_tag   (wb_tag)
    );
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [SB_FU_W-1:0]   in_fu,
    input logic [SB_NUM_FU-1:0] rd_grant,
    input logic [SB_NUM_FU-1:0] wb_grant,
    input logic [SB_NUM_FU-1:0] busy
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_grant == '0 && wb_grant == '0 && busy == '0));

    assert_busy_blocks_issue_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy[in_fu]) |-> !in_ready);

    assert_issue_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy[$past(in_fu)]);

    assert_wb_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    assert_wb_keeps_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_grant[in_fu]) |-> !in_ready);

    for (genvar u = 0; u < SB_NUM_FU; u++) begin : g_chk
        assert_single_read_R4: assert property (@(posedge clk) disable iff (rst)
            rd_grant[u] |=> !rd_grant[u]);
        assert_read_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
            rd_grant[u] |-> busy[u]);
        assert_no_read_and_write_R9: assert property (@(posedge clk) disable iff (rst)
            wb_grant[u] |-> !rd_grant[u]);
    end
endmodule

bind sb_ctrl sb_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_fu    (in_fu),
    .rd_grant (rd_grant),
    .wb_grant (wb_grant),
    .busy     (busy_vec)
);

// File: tb/tb_sb_ctrl.sv
module tb_sb_ctrl;
    import sb_pkg::*;
    localparam int N = SB_NUM_FU;
    localparam int NR = SB_NUM_REG;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SB_OP_W-1:0]  in_op = '0;
    logic [SB_REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [SB_FU_W-1:0]  in_fu = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] rd_grant, wb_grant;
    logic [SB_REG_W-1:0] wb_reg;
    logic [N*SB_OP_W-1:0] unit_op;

    always #10 clk = ~clk;   // 50 MHz

    sb_ctrl dut (.*);

    int n_checks = 0;
    int n_fail = 0;
    int unsigned seed = 32'h1234_5678;

    // reference state: 0 idle, 1 waiting operands, 2 executing, 3 finished
    int m_st[N], m_fi[N], m_fj[N], m_fk[N], m_qj[N], m_qk[N], m_op[N];
    int m_rj[N], m_rk[N], m_cnt[N];
    int m_res[NR];
    int lat[N] = '{1, 4, 2, 6};

    function automatic int rnd(input int m);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 8) % m);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    initial begin
        int pend, idle_run;
        pend = 0;
        idle_run = 0;
        for (int u = 0; u < N; u++) begin
            m_st[u] = 0; m_rj[u] = 0; m_rk[u] = 0; m_qj[u] = -1; m_qk[u] = -1;
            m_cnt[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_op[u] = 0;
        end
        for (int r = 0; r < NR; r++) m_res[r] = -1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int f = 0; f < N; f++) begin
            in_fu = SB_FU_W'(f); in_dst = SB_REG_W'(f); #1;
            check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        end
        check(rd_grant === '0, "R1 rd_grant after reset", int'(rd_grant), 0);
        check(wb_grant === '0, "R1 wb_grant after reset", int'(wb_grant), 0);

        for (int cyc = 0; cyc < 6000; cyc++) begin
            int e_ready, e_wbu, e_wbreg, iss_fu, ok_war;
            int e_rd[N];
            int old_st[N];
            int nqj, nqk;
            logic [N-1:0] e_rdv, e_wbv;
            @(negedge clk);
            // new instruction when previous one was accepted
            if (pend == 0 && rnd(8) != 0) begin
                in_fu   = SB_FU_W'(rnd(N));
                in_dst  = SB_REG_W'(rnd(6));
                in_src1 = SB_REG_W'(rnd(6));
                in_src2 = SB_REG_W'(rnd(6));
                in_op   = SB_OP_W'(rnd(16));
                pend = 1;
            end
            in_valid = (pend != 0);
            for (int u = 0; u < N; u++) begin
                if (m_st[u] == 2) done[u] = (m_cnt[u] >= lat[u]);
                else done[u] = (rnd(5) == 0);   // stray pulses (R9)
            end
            #1;
            iss_fu = int'(in_fu);
            e_ready = (m_st[iss_fu] == 0 && m_res[int'(in_dst)] == -1) ? 1 : 0;
            e_wbu = -1; e_wbreg = 0;
            for (int u = 0; u < N; u++) begin
                e_rd[u] = (m_st[u] == 1 && m_rj[u] == 1 && m_rk[u] == 1) ? 1 : 0;
                e_rdv[u] = e_rd[u][0];
            end
            for (int u = 0; u < N; u++) begin
                ok_war = 1;
                for (int f = 0; f < N; f++)
                    if (f != u && m_st[f] == 1 &&
                        ((m_fj[f] == m_fi[u] && m_rj[f] == 1) || (m_fk[f] == m_fi[u] && m_rk[f] == 1)))
                        ok_war = 0;
                if (e_wbu < 0 && m_st[u] == 3 && ok_war == 1) begin
                    e_wbu = u; e_wbreg = m_fi[u];
                end
            end
            e_wbv = '0;
            if (e_wbu >= 0) e_wbv[e_wbu] = 1'b1;

            check(int'(in_ready) == e_ready, "R2,R3,R8 in_ready", int'(in_ready), e_ready);
            check(rd_grant == e_rdv, "R4,R5 rd_grant", int'(rd_grant), int'(e_rdv));
            check(wb_grant == e_wbv, "R6,R7,R9 wb_grant", int'(wb_grant), int'(e_wbv));
            if (e_wbu >= 0)
                check(int'(wb_reg) == e_wbreg, "R7 wb_reg", int'(wb_reg), e_wbreg);
            for (int u = 0; u < N; u++)
                if (m_st[u] != 0)
                    check(int'(unit_op[u*SB_OP_W +: SB_OP_W]) == m_op[u], "R2 unit_op",
                          int'(unit_op[u*SB_OP_W +: SB_OP_W]), m_op[u]);

            // next state of the reference
            for (int u = 0; u < N; u++) old_st[u] = m_st[u];
            nqj = m_res[int'(in_src1)];
            nqk = m_res[int'(in_src2)];
            if (e_wbu >= 0 && nqj == e_wbu) nqj = -1;
            if (e_wbu >= 0 && nqk == e_wbu) nqk = -1;
            for (int u = 0; u < N; u++) begin
                if (old_st[u] == 1) begin
                    if (e_rd[u] == 1) begin
                        m_st[u] = 2; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = 0;
                    end else if (e_wbu >= 0) begin
                        if (m_qj[u] == e_wbu) begin m_qj[u] = -1; m_rj[u] = 1; end
                        if (m_qk[u] == e_wbu) begin m_qk[u] = -1; m_rk[u] = 1; end
                    end
                end else if (old_st[u] == 2) begin
                    if (done[u]) m_st[u] = 3;
                    else m_cnt[u]++;
                end
            end
            if (e_wbu >= 0) begin
                m_st[e_wbu] = 0;
                m_res[m_fi[e_wbu]] = -1;
            end
            if (in_valid && e_ready == 1) begin
                m_st[iss_fu] = 1;
                m_op[iss_fu] = int'(in_op);
                m_fi[iss_fu] = int'(in_dst);
                m_fj[iss_fu] = int'(in_src1);
                m_fk[iss_fu] = int'(in_src2);
                m_qj[iss_fu] = nqj; m_qk[iss_fu] = nqk;
                m_rj[iss_fu] = (nqj == -1) ? 1 : 0;
                m_rk[iss_fu] = (nqk == -1) ? 1 : 0;
                m_res[int'(in_dst)] = iss_fu;
                pend = 0;
                idle_run = 0;
            end else begin
                idle_run++;
            end
            if (idle_run > 400) begin
                check(1'b0, "R4,R6 progress stalled", idle_run, 0);
                break;
            end
        end
        in_valid = 1'b0;
        done = '0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule